// File: doc/BRIEF.md
# Digital potentiometer wiper controller

This block is the digital control section of a 100-tap solid-state potentiometer. A host moves the wiper over a three-wire control interface. The wires are an active-low select, a direction level and an active-low step strobe. All three arrive asynchronously and are resynchronised into the system clock domain. The wiper position lives in a saturating up/down counter that covers positions 0 to 99. That position is decoded into one hundred tap-select lines, and exactly one of them is high at any time. These lines drive the switch network of an analog resistor array that lies outside this block.

A modelled nonvolatile register shadows the position. A store happens when the host releases select while the strobe is high. If the strobe is low at that moment, select is released without a store. A store raises a busy flag for a fixed number of clock cycles, and steps that arrive while the flag is high are ignored. A recall input, asserted at power-up, copies the saved value back into the counter. The system reset clears the working logic but leaves the saved value alone. A separate power-on input puts the saved value at its factory default.

Top module: `wiper_ctl`

## Requirements
- R1: While `rst_n` is low and after it is released, `wiper_pos` is 0, `tap_sel` is 1 (bit 0 only) and `store_busy` is 0.
- R2: A falling edge of `step_n` while `sel_n` is low and `dir_up` is high raises `wiper_pos` by one, within 3 clock cycles of the edge.
- R3: A falling edge of `step_n` while `sel_n` is low and `dir_up` is low lowers `wiper_pos` by one.
- R4: The position saturates: stepping up at 99 leaves 99, stepping down at 0 leaves 0, and the position never changes by more than one per clock.
- R5: While `sel_n` is high, edges on `step_n` leave `wiper_pos` unchanged.
- R6: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper_pos`.
- R7: A rising edge of `sel_n` while `step_n` is high saves `wiper_pos` into the nonvolatile register. A later recall returns that value.
- R8: A rising edge of `sel_n` while `step_n` is low saves nothing, so a later recall returns the older saved value.
- R9: After a save, `store_busy` is high for exactly `BUSY_CYCLES` clock cycles. A `step_n` falling edge detected while it is high moves nothing.
- R10: A one-cycle `recall` pulse loads `wiper_pos` from the saved value on the next clock. `rst_n` does not clear the saved value.
- R11: Driving `por_n` low sets the saved value to `NV_DEFAULT`.
- R12: Only the falling edge of `step_n` moves the wiper. Its rising edge does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the working logic |
| por_n | input | 1 | Asynchronous active-low power-on that sets the saved value to its default |
| recall | input | 1 | Synchronous pulse: load the counter from the saved value |
| sel_n | input | 1 | Active-low chip select, asynchronous |
| dir_up | input | 1 | Step direction, 1 = up, 0 = down, asynchronous |
| step_n | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| wiper_pos | output | $clog2(N_TAPS) | Current wiper position |
| tap_sel | output | N_TAPS | One-hot tap select |
| store_busy | output | 1 | High while a save is in progress |

## Verification
A corrupt counter shows at once on `tap_sel`: either no line is high, two lines are high, or the high line does not match `wiper_pos`. A step lost or doubled in edge detection shows as a position error three clocks after the strobe edge. A wrong saved value stays hidden until the next recall, so every store and no-store case is followed by a reset and a recall that bring the saved value out on `wiper_pos`. A miscounted busy window shows at the port as the wrong number of high cycles on `store_busy`. It also shows as a step that moves the wiper when it should not, or that fails to move it after the window has closed.

// File: rtl/wiper_ctl.sv
module wiper_ctl #(
  parameter int N_TAPS      = 100,
  parameter int BUSY_CYCLES = 16,
  parameter int NV_DEFAULT  = 0,
  localparam int POS_W      = $clog2(N_TAPS),
  localparam int BW         = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              recall,
  input  logic              sel_n,
  input  logic              dir_up,
  input  logic              step_n,
  output logic [POS_W-1:0]  wiper_pos,
  output logic [N_TAPS-1:0] tap_sel,
  output logic              store_busy
);

  localparam logic [POS_W-1:0] TOP    = POS_W'(N_TAPS - 1);
  localparam logic [BW-1:0]    BUSY_N = BW'(BUSY_CYCLES);

  logic [2:0]       sel_sr, stp_sr;
  logic [1:0]       dir_sr;
  logic [POS_W-1:0] pos_q, nv_q;
  logic [BW-1:0]    busy_cnt;

  wire step_fall = stp_sr[2] & ~stp_sr[1];
  wire sel_rise  = ~sel_sr[2] & sel_sr[1];
  wire selected  = ~sel_sr[1];
  wire go_up     = dir_sr[1];
  wire store     = sel_rise & stp_sr[1];
  wire move      = step_fall & selected & ~store_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sr <= '1;
      stp_sr <= '1;
      dir_sr <= '0;
    end else begin
      sel_sr <= {sel_sr[1:0], sel_n};
      stp_sr <= {stp_sr[1:0], step_n};
      dir_sr <= {dir_sr[0], dir_up};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (recall)
      pos_q <= nv_q;
    else if (move) begin
      if (go_up && pos_q != TOP)
        pos_q <= pos_q + 1'b1;
      else if (!go_up && pos_q != '0)
        pos_q <= pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      nv_q <= POS_W'(NV_DEFAULT);
    else if (store)
      nv_q <= pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (store)
      busy_cnt <= BUSY_N;
    else if (busy_cnt != '0)
      busy_cnt <= busy_cnt - 1'b1;
  end

  assign store_busy = (busy_cnt != '0);
  assign wiper_pos  = pos_q;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign tap_sel[i] = (pos_q == POS_W'(i));
  end

  // R6: decoder output is one-hot
  a_r6_one_tap: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $countones(tap_sel) == 1);

  // R4: at most one position per clock outside a recall, no wrap
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !recall |=> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + 1'b1 ||
                 pos_q == $past(pos_q) - 1'b1));

  // R5: no move while deselected
  a_r5_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (sel_sr[1] && !recall) |=> $stable(pos_q));

  // R9: no move during a save
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (store_busy && !recall) |=> $stable(pos_q));

  // R7: busy starts with the saved value equal to the position
  a_r7_saved_value: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(store_busy) |-> nv_q == $past(pos_q));

  // R10: recall takes the saved value
  a_r10_recall_loads: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    recall |=> pos_q == $past(nv_q));

endmodule

// File: tb/wiper_ctl_tb.sv
module wiper_ctl_tb;
  localparam int N    = 100;
  localparam int BUSY = 16;
  localparam int NVD  = 5;

  logic clk = 0, rst_n = 0, por_n = 0, recall = 0;
  logic sel_n = 1, dir_up = 0, step_n = 1;
  logic [6:0]   wiper_pos;
  logic [N-1:0] tap_sel;
  logic         store_busy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wiper_ctl #(.N_TAPS(N), .BUSY_CYCLES(BUSY), .NV_DEFAULT(NVD)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .recall(recall),
    .sel_n(sel_n), .dir_up(dir_up), .step_n(step_n),
    .wiper_pos(wiper_pos), .tap_sel(tap_sel), .store_busy(store_busy));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_tap(input string req, input int p);
    checks++;
    if (tap_sel != (N'(1) << p)) begin
      fails++;
      $display("FAIL %s: actual tap %h expected one-hot bit %0d", req, tap_sel, p);
    end
  endtask

  task automatic step(input bit up);
    dir_up = up; cyc(2);
    step_n = 0; cyc(4);
    step_n = 1; cyc(4);
  endtask

  task automatic do_recall();
    recall = 1; cyc(1); recall = 0; cyc(1);
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  task automatic t_reset();
    cyc(3); por_n = 1; cyc(1);
    chk("R1 pos in reset", wiper_pos, 0);
    rst_n = 1; cyc(2);
    chk("R1 pos after reset", wiper_pos, 0);
    chk("R1 busy after reset", store_busy, 0);
    chk_tap("R1/R6 tap after reset", 0);
  endtask

  task automatic t_por_recall();
    do_recall();
    chk("R11/R10 recall of default", wiper_pos, NVD);
    chk_tap("R6 tap at default", NVD);
  endtask

  task automatic t_up_down();
    sel_n = 0; dir_up = 1; cyc(2);
    step_n = 0; cyc(4);
    chk("R2 move on falling edge", wiper_pos, NVD + 1);
    step_n = 1; cyc(4);
    chk("R12 rising edge no move", wiper_pos, NVD + 1);
    step(1); step(1);
    chk("R2 three up", wiper_pos, NVD + 3);
    chk_tap("R6 tap after up", NVD + 3);
    step(0); step(0);
    chk("R3 two down", wiper_pos, NVD + 1);
  endtask

  task automatic t_deselected();
    sel_n = 1; cyc(BUSY + 8);
    step(1); step(1);
    chk("R5 no move deselected", wiper_pos, NVD + 1);
    sel_n = 0; cyc(2);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 100; i++) step(1);
    chk("R4 saturate high", wiper_pos, 99);
    chk_tap("R6 tap at top", 99);
    for (int i = 0; i < 100; i++) step(0);
    chk("R4 saturate low", wiper_pos, 0);
    chk_tap("R6 tap at bottom", 0);
  endtask

  task automatic t_store();
    int hi = 0;
    for (int i = 0; i < 42; i++) step(1);
    sel_n = 1;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (store_busy) hi++;
    end
    chk("R9 busy length", hi, BUSY);
    do_reset();
    chk("R10 reset clears pos", wiper_pos, 0);
    do_recall();
    chk("R7/R10 recall saved 42", wiper_pos, 42);
  endtask

  task automatic t_no_store();
    sel_n = 0; cyc(2);
    step(1);
    dir_up = 1; cyc(1);
    step_n = 0; cyc(5);
    chk("R2 move before release", wiper_pos, 44);
    sel_n = 1; cyc(5);
    chk("R8 no busy without store", store_busy, 0);
    step_n = 1; cyc(4);
    chk("R5 no move on release", wiper_pos, 44);
    do_reset(); do_recall();
    chk("R8 recall old value", wiper_pos, 42);
  endtask

  task automatic t_busy_block();
    sel_n = 0; dir_up = 1; cyc(4);
    sel_n = 1; cyc(4);
    chk("R9 busy set", store_busy, 1);
    sel_n = 0; cyc(1);
    step_n = 0; cyc(4);
    step_n = 1; cyc(BUSY + 4);
    chk("R9 step ignored while busy", wiper_pos, 42);
    chk("R9 busy cleared", store_busy, 0);
    step(1);
    chk("R9 step after busy", wiper_pos, 43);
  endtask

  task automatic t_por_again();
    por_n = 0; cyc(1); por_n = 1; cyc(1);
    do_recall();
    chk("R11 por restores default", wiper_pos, NVD);
  endtask

  initial begin
    t_reset();
    t_por_recall();
    t_up_down();
    t_deselected();
    t_saturate();
    t_store();
    t_no_store();
    t_busy_block();
    t_por_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule